// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block decides, cycle by cycle, whether a bus driver may pull a single-wire bus to its dominant (low) level. The transmit-data input comes from a protocol controller: a low level asks for a dominant bus and a high level leaves the driver off, so the bus floats recessive. Before it is used, the input passes through a two-flop synchronizer. The block then guards the bus against a transmit line that is stuck low. If the synchronized input stays low for longer than a configurable number of microsecond ticks, the driver is forced off and a timeout status flag is raised.

Only one thing releases the driver, either after a timeout or on entry to normal mode: the transmit input must stay high for a minimum number of ticks. A single high sample is not enough. This rule stops a node that enters normal mode with its transmit line low from grabbing the bus. A supply-undervoltage flag blocks the driver at once, for as long as it is asserted. A build-time parameter removes the timeout entirely, so that a deliberate static low can be held on the bus.

The block runs on a system clock and takes a one-cycle microsecond tick strobe. Both limits are counted in ticks.

Top module: `txd_dom_guard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), drv_dom and tmo_flag are both 0.
- R2: txd_in passes through two flip-flops, so a change of txd_in sampled at clock edge k shows on drv_dom after edge k+1.
- R3: While the guard is armed, normal_mode is 1 and uv_flag is 0, drv_dom is the inverse of the synchronized txd_in (low input gives drv_dom = 1, high input gives drv_dom = 0).
- R4: When normal_mode goes to 1, drv_dom stays 0 until the synchronized txd_in has been high for REL_TICKS ticks without a break.
- R5: With TMO_EN = 1, if the synchronized txd_in stays low for TMO_TICKS ticks while armed, drv_dom goes to 0 and tmo_flag goes to 1, even though the input is still low.
- R6: tmo_flag stays 1, and drv_dom stays 0, until the synchronized txd_in has been high for REL_TICKS ticks without a break. A shorter high pulse neither clears the flag nor re-enables the driver.
- R7: uv_flag = 1 forces drv_dom to 0 in the same cycle. When uv_flag returns to 0 the driver resumes without a new high qualification, because the armed state is kept.
- R8: normal_mode = 0 at a clock edge disarms the guard. On return to normal mode the rule of R4 applies again.
- R9: With TMO_EN = 0, a low input is held dominant for any length of time and tmo_flag never becomes 1.
- R10: The low-time count restarts whenever the synchronized txd_in is high, so two low runs each shorter than TMO_TICKS, separated by a short high, cause no timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe marking each time unit (microsecond) |
| txd_in | input | 1 | Asynchronous transmit data, low requests dominant |
| normal_mode | input | 1 | 1 while the transceiver is in normal (transmitting) mode |
| uv_flag | input | 1 | 1 while the supply is below its undervoltage threshold |
| drv_dom | output | 1 | 1 requests the driver to pull the bus dominant |
| tmo_flag | output | 1 | 1 while a dominant timeout is latched |

## Verification
A change on txd_in reaches drv_dom two clock edges later. A change on normal_mode or uv_flag that blocks the driver shows in the same cycle, through gating. Release and timeout decisions land one edge after the tick that completes the high or low count. At that same edge, tmo_flag and the armed state update together. The bench drives inputs on the falling clock edge and steps a behavioural model on the rising edge. It compares both outputs two nanoseconds after every rising edge. The directed checks sample on falling edges, after the number of edges each of these latencies needs.

// File: rtl/txd_guard_pkg.sv
// Package: shared types and constants of the transmit dominant timeout guard.
// Assumes: nothing beyond IEEE 1800-2017.
package txd_guard_pkg;

    // Number of flip-flops in the transmit-data synchronizer.
    localparam int SYNC_STAGES = 2;

    // Guard state: the driver may pull dominant only in GRD_ARMED.
    typedef enum logic [1:0] {
        GRD_DISARMED = 2'd0,
        GRD_ARMED    = 2'd1,
        GRD_TRIPPED  = 2'd2
    } grd_state_e;

endpackage

// File: rtl/txd_guard_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes: the input is a slow level signal; the reset value is the idle level.
module txd_guard_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/txd_guard_runlen.sv
// Module: run-length timer. Counts ticks while the input sits at LEVEL,
// clears at once when the input leaves LEVEL, and saturates at LIMIT.
// Assumes: tick is a one-cycle strobe; LIMIT >= 1.
module txd_guard_runlen #(
    parameter int LIMIT = 10,
    parameter bit LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic level_in,
    output logic reached
);

    localparam int           CW  = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] run_cnt;
    logic          at_level;

    assign at_level = (level_in == LEVEL);

    // Count ticks of an unbroken run at LEVEL, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!at_level) begin
            run_cnt <= '0;
        end else if (tick && (run_cnt != LIM)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // The run counts only while the input is still at LEVEL.
    assign reached = at_level && (run_cnt == LIM);

endmodule

// File: rtl/txd_guard_ctrl.sv
// Module: guard state machine. Decides whether the driver is armed and
// whether a timeout is latched.
// Assumes: hi_ok and lo_expired are never 1 together (opposite input levels).
module txd_guard_ctrl
    import txd_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic normal_mode,
    input  logic hi_ok,
    input  logic lo_expired,
    output logic armed,
    output logic tripped
);

    grd_state_e state_q, state_d;

    // Next-state decision; an expiry wins over leaving normal mode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRD_DISARMED: if (normal_mode && hi_ok) state_d = GRD_ARMED;
            GRD_ARMED: begin
                if (lo_expired)        state_d = GRD_TRIPPED;
                else if (!normal_mode) state_d = GRD_DISARMED;
            end
            GRD_TRIPPED: begin
                if (hi_ok) state_d = normal_mode ? GRD_ARMED : GRD_DISARMED;
            end
            default: state_d = GRD_DISARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GRD_DISARMED;
        end else begin
            state_q <= state_d;
        end
    end

    assign armed   = (state_q == GRD_ARMED);
    assign tripped = (state_q == GRD_TRIPPED);

endmodule

// File: rtl/txd_dom_guard.sv
// Module: transmit dominant timeout guard (top). Synchronizes transmit data,
// qualifies high time for release, times low runs and gates the driver request.
// Assumes: tick_us is a one-cycle strobe per time unit; TMO_TICKS and
// REL_TICKS are in those units.
module txd_dom_guard
    import txd_guard_pkg::*;
#(
    parameter int TMO_TICKS = 60000,
    parameter int REL_TICKS = 11,
    parameter bit TMO_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic txd_in,
    input  logic normal_mode,
    input  logic uv_flag,
    output logic drv_dom,
    output logic tmo_flag
);

    logic txd_s;
    logic hi_ok;
    logic lo_expired;
    logic armed;

    txd_guard_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(txd_in),
        .sync_out(txd_s)
    );

    txd_guard_runlen #(
        .LIMIT(REL_TICKS),
        .LEVEL(1'b1)
    ) u_hi_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .level_in(txd_s),
        .reached (hi_ok)
    );

    generate
        if (TMO_EN) begin : g_tmo
            txd_guard_runlen #(
                .LIMIT(TMO_TICKS),
                .LEVEL(1'b0)
            ) u_lo_run (
                .clk     (clk),
                .rst_n   (rst_n),
                .tick    (tick_us),
                .level_in(txd_s),
                .reached (lo_expired)
            );
        end else begin : g_no_tmo
            assign lo_expired = 1'b0;
        end
    endgenerate

    txd_guard_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .normal_mode(normal_mode),
        .hi_ok      (hi_ok),
        .lo_expired (lo_expired),
        .armed      (armed),
        .tripped    (tmo_flag)
    );

    // Drive dominant only when armed, requested, in normal mode and supplied.
    assign drv_dom = armed && !txd_s && normal_mode && !uv_flag;

endmodule

// File: rtl/txd_dom_guard_chk.sv
// Module: assertion checker for txd_dom_guard, bound to every instance.
// Assumes: reset is held for at least two cycles at start-up.
module txd_dom_guard_chk #(
    parameter bit TMO_EN = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic txd_in,
    input logic normal_mode,
    input logic uv_flag,
    input logic drv_dom,
    input logic tmo_flag
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!drv_dom && !tmo_flag)); // R1

    AST_TWO_STAGE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom |-> !$past(txd_in, 2)); // R2

    AST_FLAG_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> !drv_dom); // R6

    AST_UV_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> !drv_dom); // R7

    AST_MODE_EXIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(normal_mode) |=> !drv_dom); // R8

    generate
        if (!TMO_EN) begin : g_off
            AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                !tmo_flag); // R9
        end
    endgenerate

endmodule

bind txd_dom_guard txd_dom_guard_chk #(.TMO_EN(TMO_EN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd_in     (txd_in),
    .normal_mode(normal_mode),
    .uv_flag    (uv_flag),
    .drv_dom    (drv_dom),
    .tmo_flag   (tmo_flag)
);

// File: tb/txd_dom_guard_tb_top.sv
// Bench: two guards (timeout on and off) share the same stimulus. A
// behavioural model is stepped on each rising edge and compared 2 ns later.
// Directed checks sample on falling edges.
module txd_dom_guard_tb_top;

    localparam int TMO = 20;
    localparam int REL = 3;
    localparam int TDIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic txd_in = 1'b1;
    logic normal_mode = 1'b0;
    logic uv_flag = 1'b0;
    logic drv_a, flag_a, drv_b, flag_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tdiv_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    txd_dom_guard #(.TMO_TICKS(TMO), .REL_TICKS(REL), .TMO_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .txd_in(txd_in),
        .normal_mode(normal_mode), .uv_flag(uv_flag),
        .drv_dom(drv_a), .tmo_flag(flag_a));

    txd_dom_guard #(.TMO_TICKS(TMO), .REL_TICKS(REL), .TMO_EN(1'b0)) dut_nt_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .txd_in(txd_in),
        .normal_mode(normal_mode), .uv_flag(uv_flag),
        .drv_dom(drv_b), .tmo_flag(flag_b));

    // Behavioural reference state, index 0 = timeout on, 1 = timeout off.
    bit   m_s1 [2];
    bit   m_s2 [2];
    int   m_hi [2];
    int   m_lo [2];
    bit   m_arm [2];
    bit   m_flag [2];
    bit   m_drv [2];

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Tick strobe, driven on falling edges.
    always @(negedge clk) begin
        tdiv_cnt = (tdiv_cnt + 1) % TDIV;
        tick_us <= (tdiv_cnt == 0);
    end

    // Model step on every rising edge.
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            bit en, hi_ok, expd;
            en = (k == 0);
            if (!rst_n) begin
                m_s1[k] = 1; m_s2[k] = 1; m_hi[k] = 0; m_lo[k] = 0;
                m_arm[k] = 0; m_flag[k] = 0;
            end else begin
                hi_ok = m_s2[k] && (m_hi[k] >= REL);
                expd  = en && !m_s2[k] && (m_lo[k] >= TMO);
                if (m_arm[k] && expd) m_flag[k] = 1;
                else if (hi_ok) m_flag[k] = 0;
                if (!normal_mode || expd) m_arm[k] = 0;
                else if (hi_ok) m_arm[k] = 1;
                if (m_s2[k]) begin
                    m_lo[k] = 0;
                    if (tick_us && m_hi[k] < REL) m_hi[k]++;
                end else begin
                    m_hi[k] = 0;
                    if (tick_us && m_lo[k] < TMO) m_lo[k]++;
                end
                m_s2[k] = m_s1[k];
                m_s1[k] = txd_in;
            end
        end
    end

    // Per-cycle comparison against the model, 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        for (int k = 0; k < 2; k++)
            m_drv[k] = m_arm[k] && !m_s2[k] && !uv_flag && normal_mode;
        if (rst_n && !done) begin
            chk("MODEL drv (R3)", drv_a, m_drv[0]);
            chk("MODEL flag (R5)", flag_a, m_flag[0]);
            chk("MODEL drv no-timeout (R9)", drv_b, m_drv[1]);
            chk("MODEL flag no-timeout (R9)", flag_b, m_flag[1]);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 drv after reset", drv_a, 1'b0);
        chk("R1 flag after reset", flag_a, 1'b0);

        // R4: entry to normal mode with the input low must not drive.
        txd_in = 1'b0;
        wait_cyc(4);
        normal_mode = 1'b1;
        wait_cyc(40);
        chk("R4 low at mode entry blocked", drv_a, 1'b0);
        txd_in = 1'b1;
        wait_cyc(6);
        chk("R4 short high not armed yet", drv_a, 1'b0);
        wait_cyc(20);
        txd_in = 1'b0;
        wait_cyc(3);
        chk("R3 low gives dominant", drv_a, 1'b1);
        txd_in = 1'b1;
        wait_cyc(3);
        chk("R3 high gives recessive", drv_a, 1'b0);

        // R2: two-edge latency from txd_in to drv_dom.
        wait_cyc(2);
        txd_in = 1'b0;
        wait_cyc(1);
        chk("R2 one edge not yet", drv_a, 1'b0);
        wait_cyc(1);
        chk("R2 two edges dominant", drv_a, 1'b1);

        // R10: two sub-limit low runs split by a short high.
        wait_cyc(60);
        txd_in = 1'b1;
        wait_cyc(2);
        txd_in = 1'b0;
        wait_cyc(60);
        chk("R10 still dominant", drv_a, 1'b1);
        chk("R10 no timeout", flag_a, 1'b0);

        // R5 and R9: a long low trips one guard only.
        wait_cyc(100);
        chk("R5 driver forced off", drv_a, 1'b0);
        chk("R5 flag set", flag_a, 1'b1);
        chk("R9 static low held", drv_b, 1'b1);
        chk("R9 no flag", flag_b, 1'b0);

        // R6: a short high does not release; a long one does.
        txd_in = 1'b1;
        wait_cyc(4);
        txd_in = 1'b0;
        wait_cyc(8);
        chk("R6 flag held after short high", flag_a, 1'b1);
        chk("R6 driver still off", drv_a, 1'b0);
        txd_in = 1'b1;
        wait_cyc(30);
        chk("R6 flag cleared", flag_a, 1'b0);
        txd_in = 1'b0;
        wait_cyc(3);
        chk("R6 driver released", drv_a, 1'b1);

        // R7: undervoltage blocks at once and keeps the armed state.
        uv_flag = 1'b1;
        wait_cyc(1);
        chk("R7 uv blocks", drv_a, 1'b0);
        uv_flag = 1'b0;
        wait_cyc(1);
        chk("R7 resumes after uv", drv_a, 1'b1);

        // R8: leaving normal mode disarms; re-entry needs the high time again.
        normal_mode = 1'b0;
        wait_cyc(5);
        chk("R8 off in sleep", drv_a, 1'b0);
        normal_mode = 1'b1;
        wait_cyc(20);
        chk("R8 not rearmed by low", drv_a, 1'b0);
        txd_in = 1'b1;
        wait_cyc(20);
        txd_in = 1'b0;
        wait_cyc(3);
        chk("R8 rearmed after high", drv_a, 1'b1);

        wait_cyc(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule